// File: doc/BRIEF.md
# Output Impedance Calibration Controller

This block keeps the 5-bit setting of an output driver's impedance and moves that setting slowly toward the value an external analog comparator asks for. The comparator result comes in as two level inputs, one asking for a higher code and one asking for a lower code. A free-running interval counter samples that request once per evaluation period. Each evaluation moves a pending code by one step at most, and the pending code saturates at both ends of its range.

The pending code does not reach the driver right away. It is copied into the applied code only on a cycle in which the outputs go from driving to high impedance. The outputs are in high impedance during a write cycle, during a deselect cycle, or while the output-enable input is inactive. This means the driver strength never changes while data is on the bus.

A calibrated flag rises when two conditions have both been met: a warm-up period has elapsed since reset, and a driving-to-high-impedance transition has then applied a code. The flag stays high until the next reset.

Top module: `zq_cal_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `drv_code` equals the mid-range start value 16 and `calibrated` is 0.
- R2: The comparator request is sampled exactly once per 64 clock cycles. The first sample is taken on the 64th rising edge after reset release, and the pending code changes on no other edge.
- R3: At each sample, `cmp_up` alone raises the pending code by one and `cmp_dn` alone lowers it by one. Both inputs high, or both low, leave the pending code unchanged.
- R4: The pending code stops at 31 when raised and stops at 0 when lowered. It never wraps around.
- R5: The outputs are in high impedance when `wr_cyc`, `desel_cyc` or `oe_n` is 1. `drv_code` takes the pending code on the rising edge where the outputs are in high impedance and were driving on the previous edge. Reset counts as high impedance. `drv_code` changes on no other edge.
- R6: `calibrated` becomes 1 on the first R5 update edge that comes at least 4096 rising edges after reset release. It stays 1 until reset.
- R7: If the outputs stay in high impedance continuously, `drv_code` keeps its value however many evaluations take place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_cyc | input | 1 | A write cycle is in progress (outputs in high impedance) |
| desel_cyc | input | 1 | A deselect cycle is in progress (outputs in high impedance) |
| oe_n | input | 1 | Output enable, active low; when 1 the outputs are in high impedance |
| cmp_up | input | 1 | Comparator requests a higher code |
| cmp_dn | input | 1 | Comparator requests a lower code |
| drv_code | output | 5 | Code applied to the output driver |
| calibrated | output | 1 | Warm-up has elapsed and a qualifying code update has taken place |

## Verification
The assertions assume that all inputs are synchronous and settled at each rising edge. They also assume that the comparator request may take any combination of values, including both directions at once, and that the high-impedance sources may overlap. The stimulus changes every input only at the falling edge. The random phase mixes all four combinations of the comparator inputs with write, deselect and output-enable patterns of different densities. Directed phases hold the outputs in high impedance for a long time, and they drive the code into both saturation ends before applying it.

// File: rtl/zq_cal_ctrl.sv
module zq_cal_ctrl #(
  parameter int CODE_W        = 5,
  parameter int EVAL_PERIOD   = 64,
  parameter int WARMUP_CYCLES = 4096,
  parameter int RESET_CODE    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cyc,
  input  logic              desel_cyc,
  input  logic              oe_n,
  input  logic              cmp_up,
  input  logic              cmp_dn,
  output logic [CODE_W-1:0] drv_code,
  output logic              calibrated
);

  localparam int EW = $clog2(EVAL_PERIOD);
  localparam int WW = $clog2(WARMUP_CYCLES + 1);
  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(RESET_CODE);

  logic [EW-1:0]     ev_cnt;
  logic [WW-1:0]     wu_cnt;
  logic [CODE_W-1:0] pend;
  logic              hiz_q;

  wire hiz       = wr_cyc | desel_cyc | oe_n;
  wire apply     = hiz & ~hiz_q;
  wire tick      = (ev_cnt == EW'(EVAL_PERIOD - 1));
  wire warm_done = (wu_cnt == WW'(WARMUP_CYCLES));
  wire go_up     = cmp_up & ~cmp_dn & (pend != CODE_MAX);
  wire go_dn     = cmp_dn & ~cmp_up & (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cnt     <= '0;
      wu_cnt     <= '0;
      pend       <= CODE_INIT;
      hiz_q      <= 1'b1;
      drv_code   <= CODE_INIT;
      calibrated <= 1'b0;
    end else begin
      ev_cnt <= tick ? '0 : ev_cnt + 1'b1;
      if (!warm_done) wu_cnt <= wu_cnt + 1'b1;
      if (tick && go_up) pend <= pend + 1'b1;
      else if (tick && go_dn) pend <= pend - 1'b1;
      hiz_q <= hiz;
      if (apply) drv_code <= pend;
      if (apply && warm_done) calibrated <= 1'b1;
    end
  end

  // pending code moves only right after an evaluation tick
  assert_eval_only_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != $past(pend)) |-> $past(tick));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != $past(pend)) |->
      (({1'b0, pend} == {1'b0, $past(pend)} + 1'b1) ||
       ({1'b0, pend} + 1'b1 == {1'b0, $past(pend)})));

  assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) == CODE_MAX) |-> (pend != '0));

  assert_no_wrap_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) == '0) |-> (pend != CODE_MAX));

  assert_apply_in_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_code != $past(drv_code)) |-> ($past(hiz) && !$past(hiz_q)));

  assert_cal_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    calibrated |=> calibrated);

  assert_cal_after_warmup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calibrated) |-> ($past(warm_done) && $past(apply)));

endmodule

// File: tb/zq_cal_ctrl_tb_top.sv
module zq_cal_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_cyc = 1'b0, desel_cyc = 1'b0, oe_n = 1'b1, cmp_up = 1'b0, cmp_dn = 1'b0;
  logic [4:0] drv_code;
  logic calibrated;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zq_cal_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_cyc(wr_cyc), .desel_cyc(desel_cyc), .oe_n(oe_n),
    .cmp_up(cmp_up), .cmp_dn(cmp_dn), .drv_code(drv_code), .calibrated(calibrated)
  );

  // reference state derived from the requirements
  int  m_ev, m_wu, m_pend, m_code;
  bit  m_hizq, m_cal;

  function automatic int next_pend(int p, bit up, bit dn);
    if (up && !dn) return (p < 31) ? p + 1 : 31;   // R3, R4
    if (dn && !up) return (p > 0) ? p - 1 : 0;
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ev <= 0; m_wu <= 0; m_pend <= 16; m_code <= 16; m_hizq <= 1'b1; m_cal <= 1'b0;
    end else begin
      bit hz;
      hz = wr_cyc | desel_cyc | oe_n;
      m_ev <= (m_ev == 63) ? 0 : m_ev + 1;                        // R2
      if (m_wu < 4096) m_wu <= m_wu + 1;
      if (m_ev == 63) m_pend <= next_pend(m_pend, cmp_up, cmp_dn);
      m_hizq <= hz;
      if (hz && !m_hizq) begin                                    // R5
        m_code <= m_pend;
        if (m_wu == 4096) m_cal <= 1'b1;                          // R6
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R2/R3/R4/R5 drv_code", int'(drv_code), m_code);
    check("R6 calibrated", int'(calibrated), int'(m_cal));
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_lowz();
    oe_n = 1'b0; wr_cyc = 1'b0; desel_cyc = 1'b0;
    @(negedge clk);
    oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    cmp_up = 1'b1;
    cycles(3);
    check("R1 reset code", int'(drv_code), 16);
    check("R1 reset calibrated", int'(calibrated), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after release", int'(drv_code), 16);
    // R7: stay in high impedance for three evaluations
    cycles(199);
    check("R7 code held while high-Z", int'(drv_code), 16);
    pulse_lowz();
    check("R5 pending applied on edge (3 steps)", int'(drv_code), 19);
    check("R6 not calibrated before warm-up", int'(calibrated), 0);
    // R4 top saturation with periodic windows
    for (int k = 0; k < 30; k++) begin cycles(62); pulse_lowz(); end
    check("R4 saturate at 31", int'(drv_code), 31);
    // R6 after warm-up
    cycles(2300);
    pulse_lowz();
    check("R6 calibrated after warm-up and edge", int'(calibrated), 1);
    // R3 both requests: no change
    cmp_dn = 1'b1;
    for (int k = 0; k < 3; k++) begin cycles(62); pulse_lowz(); end
    check("R3 both requests hold", int'(drv_code), 31);
    // R4 bottom saturation
    cmp_up = 1'b0;
    for (int k = 0; k < 36; k++) begin cycles(62); pulse_lowz(); end
    check("R4 saturate at 0", int'(drv_code), 0);
    // random mix
    for (int k = 0; k < 6000; k++) begin
      wr_cyc    = ($urandom % 4) == 0;
      desel_cyc = ($urandom % 8) == 0;
      oe_n      = ($urandom % 8) == 0;
      if (k % 64 == 0) begin
        cmp_up = $urandom % 2;
        cmp_dn = $urandom % 2;
      end
      @(negedge clk);
    end
    check("R6 calibrated stays set", int'(calibrated), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again code", int'(drv_code), 16);
    check("R1 reset again calibrated", int'(calibrated), 0);
    finish_run();
  end
endmodule